// File: doc/BRIEF.md
# Streaming Multi-Word Program Sequencer

This block runs a burst-programming operation on a word-wide nonvolatile array model that sits inside it. After the unlock sequence (three writes: AAh at 555h, 55h at 2AAh, 20h at 555h) has been decoded upstream, a one-cycle `start` pulse arrives together with the address of the last unlock write. The block then takes a stream of bus writes in two passes.

In the first pass, the program pass, each word is written into the array. In the second pass, the verify pass, the same words are sent again and compared against the stored contents. Data words carry no address of their own. The first write of a pass fixes the starting location. Later writes only say, through their upper address field, whether the burst goes on or has ended. An internal counter steps through the array locations.

While a word is being processed, `wip` is high. When `wip` drops low, the next word may be sent. An error is held on `fail` until a reset code is written.

Top module: `burst_prog_seq`

## Requirements
- R1: A `start` pulse while idle begins an operation in the program pass. From the next cycle `active` is 1 and `verify_ph` is 0. Bits 21..17 of `wr_addr` at the `start` pulse become the reference field.
- R2: The first write of a pass whose bits 21..17 match the reference field is the start write. Its data is handled at array location `wr_addr[ARR_AW-1:0]`.
- R3: A later write whose bits 21..17 match the reference field is a continue write. Its data goes to the location after the previous word. Address bits 16..0 of a continue write have no effect.
- R4: A write whose bits 21..17 differ from the reference field ends the pass, and its data is not stored. Ending the program pass sets `verify_ph` to 1. Ending the verify pass with no error drops `active` to 0.
- R5: Each accepted word holds `wip` high for exactly BUSY_CYC cycles. Writes that arrive while `wip` is high are dropped and do not move the location counter.
- R6: In the program pass, a word with a 1 where the stored word has a 0 is not written. It raises `fail`. Otherwise the array location takes the word.
- R7: In the verify pass, a word equal to the stored word leaves the array unchanged. A word that differs only by clearing bits is written again. A word needing any 0 turned to 1 raises `fail`.
- R8: Once raised, `fail` (with `active`) holds until a write whose `wr_data[7:0]` is F0h arrives. That write returns the block to idle.
- R9: While `active` is 1, the `start` input has no effect. A data word of F0h is ordinary data; it does not abort or pause the operation.
- R10: A pass ended by its very first write holds zero words. An empty program pass moves on to the verify pass, and an empty verify pass ends with `fail` at 0.
- R11: The array starts with every bit set. Writes while idle change nothing. `rd_data` returns the word at `rd_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Unlock decoded; begins an operation |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data |
| rd_addr | input | ARR_AW | Array read address |
| rd_data | output | DATA_W | Registered array read data |
| active | output | 1 | Operation in progress or error held |
| verify_ph | output | 1 | Verify pass in progress |
| wip | output | 1 | Word being processed; next write must wait |
| fail | output | 1 | Error held |

## Verification
Bursts are driven with continue writes whose low address bits are arbitrary. This separates counter-based placement from address-based placement. Writes fired back to back, without waiting on `wip`, show whether words arriving during processing are dropped. Verify passes are sent with words that are equal, words that only clear further bits, and words that need a bit set. These three cases tell apart no action, rewrite and failure. Empty passes, a stray `start` mid-burst, an F0h data word and writes while idle check that the pass boundaries and command filtering follow the address field alone.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PFIRST,
    ST_PRUN,
    ST_VFIRST,
    ST_VRUN,
    ST_BUSY,
    ST_FAIL
  } bps_state_e;

  localparam logic [7:0] BPS_CLEAR_CODE = 8'hF0;
endpackage

// File: rtl/bps_word_mem.sv
module bps_word_mem #(
  parameter int DATA_W = 16,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [AW-1:0]     b_addr,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/bps_wait_timer.sv
module bps_wait_timer #(
  parameter int CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= LOAD_V;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/bps_word_check.sv
module bps_word_check #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] stored,
  input  logic [DATA_W-1:0] incoming,
  output logic              needs_set,
  output logic              same
);
  always_comb begin
    needs_set = |(incoming & ~stored);
    same      = (incoming == stored);
  end
endmodule

// File: rtl/burst_prog_seq.sv
module burst_prog_seq
  import bps_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int FLD_LO   = 17,
  parameter int DATA_W   = 16,
  parameter int ARR_AW   = 6,
  parameter int BUSY_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ARR_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              active,
  output logic              verify_ph,
  output logic              wip,
  output logic              fail
);
  localparam int FW  = ADDR_W - FLD_LO;
  localparam int BC  = (BUSY_CYC < 2) ? 2 : BUSY_CYC;
  localparam int LCW = $clog2(BC + 2) + 1;

  bps_state_e        state;
  logic              vflag;
  logic [FW-1:0]     ref_fld;
  logic [ARR_AW-1:0] cnt;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] old_word;
  logic              tmr_load, tmr_done;
  logic              needs_set, same;
  logic              mem_we;
  logic              fld_hit;
  logic              clear_cmd;
  logic              unused_mid;

  assign unused_mid = ^wr_addr[FLD_LO-1:ARR_AW];
  assign fld_hit    = (wr_addr[ADDR_W-1:FLD_LO] == ref_fld);
  assign clear_cmd  = (wr_data[7:0] == BPS_CLEAR_CODE);

  assign tmr_load = wr_en && fld_hit &&
                    (state == ST_PFIRST || state == ST_PRUN ||
                     state == ST_VFIRST || state == ST_VRUN);

  assign mem_we = (state == ST_BUSY) && tmr_done && !needs_set &&
                  (!vflag || !same);

  bps_wait_timer #(.CYC(BC)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .done (tmr_done)
  );

  bps_word_check #(.DATA_W(DATA_W)) u_chk (
    .stored    (old_word),
    .incoming  (data_q),
    .needs_set (needs_set),
    .same      (same)
  );

  bps_word_mem #(.DATA_W(DATA_W), .AW(ARR_AW)) u_mem (
    .clk     (clk),
    .a_we    (mem_we),
    .a_addr  (cnt),
    .a_wdata (data_q),
    .a_rdata (old_word),
    .b_addr  (rd_addr),
    .b_rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      vflag   <= 1'b0;
      ref_fld <= '0;
      cnt     <= '0;
      data_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            ref_fld <= wr_addr[ADDR_W-1:FLD_LO];
            state   <= ST_PFIRST;
          end
        end
        ST_PFIRST, ST_VFIRST: begin
          if (wr_en) begin
            if (fld_hit) begin
              cnt    <= wr_addr[ARR_AW-1:0];
              data_q <= wr_data;
              vflag  <= (state == ST_VFIRST);
              state  <= ST_BUSY;
            end else begin
              state <= (state == ST_PFIRST) ? ST_VFIRST : ST_IDLE;
            end
          end
        end
        ST_PRUN, ST_VRUN: begin
          if (wr_en) begin
            if (fld_hit) begin
              data_q <= wr_data;
              vflag  <= (state == ST_VRUN);
              state  <= ST_BUSY;
            end else begin
              state <= (state == ST_PRUN) ? ST_VFIRST : ST_IDLE;
            end
          end
        end
        ST_BUSY: begin
          if (tmr_done) begin
            if (needs_set) begin
              state <= ST_FAIL;
            end else begin
              cnt   <= cnt + 1'b1;
              state <= vflag ? ST_VRUN : ST_PRUN;
            end
          end
        end
        ST_FAIL: begin
          if (wr_en && clear_cmd) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign active    = (state != ST_IDLE);
  assign wip       = (state == ST_BUSY);
  assign fail      = (state == ST_FAIL);
  assign verify_ph = (state == ST_VFIRST) || (state == ST_VRUN) ||
                     ((state == ST_BUSY) && vflag);

  // checker-side length counter for the busy window
  logic [LCW-1:0] wip_len;
  always_ff @(posedge clk) begin
    if (rst)      wip_len <= '0;
    else if (wip) wip_len <= wip_len + 1'b1;
    else          wip_len <= '0;
  end

  // R5
  wip_window_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> (wip_len == LCW'(BC)));

  // R5
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wip && $past(wip)) |-> $stable(cnt));

  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fail && !(wr_en && clear_cmd)) |=> fail);

  // R9
  no_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !wr_en) |=> active);

  // R4
  verify_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(verify_ph) |-> (!active || fail));
endmodule

// File: tb/tb_burst_prog_seq.sv
module tb_burst_prog_seq;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 22;
  localparam int DATA_W = 16;
  localparam int AW     = 6;
  localparam int BC     = 3;
  localparam logic [4:0] FA = 5'h03;
  localparam logic [4:0] FB = 5'h04;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [AW-1:0]     rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              active, verify_ph, wip, fail;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  burst_prog_seq #(.ADDR_W(ADDR_W), .FLD_LO(17), .DATA_W(DATA_W),
                   .ARR_AW(AW), .BUSY_CYC(BC)) dut (
    .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .active(active), .verify_ph(verify_ph), .wip(wip), .fail(fail)
  );

  function automatic logic [ADDR_W-1:0] mk(input logic [4:0] f, input logic [16:0] lo);
    return {f, lo};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic word(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, output int n);
    wr(a, d);
    n = 0;
    while (wip && n < 50) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic go(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    start = 1'b1; wr_addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] d;
    chk(!active && !wip && !fail && !verify_ph, "R1 reset flags",
        {active, verify_ph, wip, fail}, 0);
    rd(6'h05, d);
    chk(d == 16'hFFFF, "R11 erased after reset", d, 16'hFFFF);
  endtask

  task automatic t_idle_ignore();
    logic [DATA_W-1:0] d;
    wr(mk(FA, 17'h05), 16'h0000);
    chk(!wip && !active, "R11 idle write no op", {active, wip}, 0);
    rd(6'h05, d);
    chk(d == 16'hFFFF, "R11 idle write array", d, 16'hFFFF);
  endtask

  task automatic t_basic();
    int n;
    logic [DATA_W-1:0] d;
    go(mk(FA, 17'h555));
    chk(active && !verify_ph, "R1 program pass entered", {active, verify_ph}, 2);
    word(mk(FA, 17'h10), 16'h1234, n);
    chk(n == BC, "R5 busy length", n, BC);
    word(mk(FA, 17'h1FF3F), 16'h5678, n);
    word(mk(FA, 17'h00007), 16'h12F0, n);
    chk(active && !fail, "R9 F0 data word kept going", {active, fail}, 2);
    wr(mk(FB, 17'h11), 16'h0000);
    chk(verify_ph && active && !wip, "R4 verify after program final",
        {active, verify_ph, wip}, 6);
    rd(6'h10, d); chk(d == 16'h1234, "R2 start word", d, 16'h1234);
    rd(6'h11, d); chk(d == 16'h5678, "R3 continue word", d, 16'h5678);
    rd(6'h12, d); chk(d == 16'h12F0, "R3 second continue", d, 16'h12F0);
    rd(6'h13, d); chk(d == 16'hFFFF, "R4 final data not stored", d, 16'hFFFF);
    word(mk(FA, 17'h10), 16'h1234, n);
    word(mk(FA, 17'h00000), 16'h5678, n);
    word(mk(FA, 17'h1FFFF), 16'h12F0, n);
    wr(mk(FB, 17'h0), 16'h0000);
    chk(!active && !fail, "R4 verify pass ok", {active, fail}, 0);
  endtask

  task automatic t_drop();
    int n;
    logic [DATA_W-1:0] d;
    go(mk(FA, 17'h0));
    wr(mk(FA, 17'h18), 16'hAAAA);
    wr(mk(FA, 17'h0), 16'h5555);
    n = 0;
    while (wip && n < 50) begin @(negedge clk); n++; end
    word(mk(FA, 17'h0), 16'h3333, n);
    wr(mk(FB, 17'h0), 16'h0);
    rd(6'h18, d); chk(d == 16'hAAAA, "R5 word before drop", d, 16'hAAAA);
    rd(6'h19, d); chk(d == 16'h3333, "R5 dropped write skipped", d, 16'h3333);
    word(mk(FA, 17'h18), 16'hAAAA, n);
    word(mk(FA, 17'h0), 16'h3333, n);
    wr(mk(FB, 17'h0), 16'h0);
    chk(!active && !fail, "R5 burst with drop verifies", {active, fail}, 0);
  endtask

  task automatic t_start_and_reprog();
    int n;
    logic [DATA_W-1:0] d;
    go(mk(FA, 17'h0));
    word(mk(FA, 17'h20), 16'h0FF0, n);
    go(mk(FB, 17'h555));
    chk(active && !verify_ph, "R9 start ignored while active", {active, verify_ph}, 2);
    word(mk(FA, 17'h0), 16'h0FF1, n);
    rd(6'h21, d); chk(d == 16'h0FF1, "R9 reference field kept", d, 16'h0FF1);
    wr(mk(FB, 17'h0), 16'h0);
    word(mk(FA, 17'h20), 16'h0F00, n);
    word(mk(FA, 17'h0), 16'h0FF1, n);
    wr(mk(FB, 17'h0), 16'h0);
    chk(!active && !fail, "R7 reprogram passes", {active, fail}, 0);
    rd(6'h20, d); chk(d == 16'h0F00, "R7 rewritten word", d, 16'h0F00);
  endtask

  task automatic t_zero();
    go(mk(FA, 17'h0));
    wr(mk(FB, 17'h0), 16'h0);
    chk(active && verify_ph, "R10 empty program to verify", {active, verify_ph}, 3);
    wr(mk(FB, 17'h0), 16'h0);
    chk(!active && !fail, "R10 empty verify ok", {active, fail}, 0);
  endtask

  task automatic t_prog_fail();
    int n;
    logic [DATA_W-1:0] d;
    go(mk(FA, 17'h0));
    word(mk(FA, 17'h20), 16'hFFFF, n);
    chk(fail && active, "R6 set bit raises fail", {active, fail}, 3);
    rd(6'h20, d); chk(d == 16'h0F00, "R6 word not written", d, 16'h0F00);
    wr(mk(FA, 17'h0), 16'h00F1);
    chk(fail, "R8 non clear write keeps fail", fail, 1);
    go(mk(FA, 17'h0));
    chk(fail, "R8 start keeps fail", fail, 1);
    wr(mk(FB, 17'h3), 16'hABF0);
    chk(!active && !fail, "R8 clear code to idle", {active, fail}, 0);
  endtask

  task automatic t_ver_fail();
    int n;
    logic [DATA_W-1:0] d;
    go(mk(FA, 17'h0));
    word(mk(FA, 17'h28), 16'h00F0, n);
    wr(mk(FB, 17'h0), 16'h0);
    word(mk(FA, 17'h28), 16'h00FF, n);
    chk(fail && !verify_ph, "R7 verify set bit fails", {verify_ph, fail}, 1);
    rd(6'h28, d); chk(d == 16'h00F0, "R7 failed word unchanged", d, 16'h00F0);
    wr(mk(FA, 17'h0), 16'h00F0);
    chk(!active && !fail, "R8 clear after verify fail", {active, fail}, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_ignore();
    t_basic();
    t_drop();
    t_start_and_reprog();
    t_zero();
    t_prog_fail();
    t_ver_fail();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule